// File: doc/BRIEF.md
# Segment Access Limit and Privilege Checker

This block takes one data access, together with the segment descriptor already loaded for that access, and decides whether the access may go ahead. It checks three things: that the segment is present, that the requester has enough privilege, and that every byte of the access lies inside the segment limit. It also forms the linear address as the segment base plus the offset.

The result comes out one clock after the request, through a single register stage. Each response carries a valid strobe, the linear address and a two-bit fault code. When more than one problem applies, the code reports only the most important one.

The block sits between the address-generation stage and the translation stage of a load/store path. Fetching descriptors from tables, gates, task switches and code-segment rules are handled elsewhere.

Top module: `seg_access_check`

## Requirements
- R1: When a request is accepted, the linear address one cycle later equals descriptor base plus offset, modulo 2^32. This holds whether or not the access faults.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: The effective level is the larger of `cur_lvl` and selector bits 1..0. An effective level numerically greater than `dsc_lvl` gives a protection fault. Selector bits 15..2 have no effect on the result.
- R4: With `dsc_gran`=0 the limit counts bytes. The access size code gives 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. A limit fault is raised when offset plus bytes minus 1, computed without wrap-around, exceeds the limit.
- R5: With `dsc_gran`=1 the effective limit is the 20-bit limit followed by twelve 1 bits, so a limit of 0xFFFFF covers the full 4 GB.
- R6: Bit 1 of `dsc_type` marks the segment writable. A write to a segment with that bit at 0 gives a protection fault; a read of the same segment does not.
- R7: A descriptor with `dsc_present`=0 gives a not-present fault.
- R8: Fault codes are 0 for none, 1 for not-present, 2 for protection and 3 for limit. Not-present outranks protection, and protection outranks limit.
- R9: After reset, `rsp_valid`, `rsp_fault` and `rsp_lin` are all 0.
- R10: In a cycle with `req_valid` low, `rsp_fault` and `rsp_lin` keep their values on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_sel | input | 16 | Segment selector; bits 1..0 are the requester level |
| cur_lvl | input | 2 | Current privilege level |
| req_off | input | 32 | Byte offset into the segment |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Log2 of access bytes |
| dsc_base | input | 32 | Segment base |
| dsc_limit | input | 20 | Segment limit |
| dsc_gran | input | 1 | Limit unit: 0 byte, 1 4 KB |
| dsc_lvl | input | 2 | Descriptor privilege level |
| dsc_present | input | 1 | Segment present |
| dsc_type | input | 4 | Segment type; bit 1 = writable |
| rsp_valid | output | 1 | Result strobe |
| rsp_lin | output | 32 | Linear address |
| rsp_fault | output | 2 | Fault code |

## Verification
The bench targets the following corner cases:

- **Last byte of the limit.** It runs accesses whose last byte lands exactly on the limit and one byte past it. A design that compared only the first byte, or used `>=` instead of `>`, would pass or fault the wrong one of these.
- **Offsets that wrap past 4 GB.** With a full-range scaled limit, it runs an offset whose last byte wraps past the top of the address space. A 32-bit sum would wrap and let that access through.
- **Effective level.** It raises the level once through the selector and once through the current level. This catches a design that looks at only one of the two.
- **Stacked faults.** It runs descriptors with several faults at once, which exposes a wrong priority order.
- **Read-only segments.** It sends both a read and a write to a read-only segment, so a design that faulted both directions would be caught.

// File: rtl/seg_chk_pkg.sv
// Package: shared fault encoding for the segment access checker.
// Assumes a 2-bit fault code; order of values is part of the interface.
package seg_chk_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_LIMIT   = 2'd3
    } seg_fault_e;
endpackage

// File: rtl/seg_lvl_check.sv
// Module: privilege and write-permission check.
// Works out the effective level as the larger of the current level and the
// requester level, and flags a protection violation. Purely combinational.
module seg_lvl_check #(
    parameter int LVL_W      = 2,
    parameter int TYPE_W     = 4,
    parameter int WR_BIT     = 1
) (
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic [LVL_W-1:0]  rq_lvl,
    input  logic [LVL_W-1:0]  dsc_lvl,
    input  logic [TYPE_W-1:0] dsc_type,
    input  logic              is_write,
    output logic              prot_err
);
    logic [LVL_W-1:0] eff_lvl;

    // Pick the weaker (numerically larger) level, then compare and check writes.
    always_comb begin
        eff_lvl  = (cur_lvl > rq_lvl) ? cur_lvl : rq_lvl;
        prot_err = (eff_lvl > dsc_lvl) || (is_write && !dsc_type[WR_BIT]);
    end
endmodule

// File: rtl/seg_lim_check.sv
// Module: limit check with granularity scaling.
// Computes the last byte touched, without wrap-around, and compares it to the
// scaled limit. Assumes LIMIT_W + GRAN_SHIFT <= ADDR_W. Combinational.
module seg_lim_check #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int GRAN_SHIFT = 12,
    parameter int SIZE_W     = 2
) (
    input  logic [ADDR_W-1:0]  offset,
    input  logic [SIZE_W-1:0]  size_log2,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               gran,
    output logic               lim_err
);
    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] eff_limit;
    logic [EXT_W-1:0]  span;
    logic [EXT_W-1:0]  last_byte;

    // Scale the limit, form the last byte address and compare.
    always_comb begin
        if (gran)
            eff_limit = ADDR_W'({limit, {GRAN_SHIFT{1'b1}}});
        else
            eff_limit = ADDR_W'(limit);
        span      = (EXT_W'(1) << size_log2) - EXT_W'(1);
        last_byte = {1'b0, offset} + span;
        lim_err   = last_byte > {1'b0, eff_limit};
    end
endmodule

// File: rtl/seg_access_check.sv
// Module: segment access checker top.
// Forms base+offset, ranks the faults (absent > protection > limit) and
// registers the result in one stage. Synchronous active-low reset; result
// registers hold while no request is present.
module seg_access_check
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int GRAN_SHIFT = 12,
    parameter int SEL_W      = 16,
    parameter int LVL_W      = 2,
    parameter int SIZE_W     = 2,
    parameter int TYPE_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        cur_lvl,
    input  logic [31:0]       req_off,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [31:0]       dsc_base,
    input  logic [19:0]       dsc_limit,
    input  logic              dsc_gran,
    input  logic [1:0]        dsc_lvl,
    input  logic              dsc_present,
    input  logic [3:0]        dsc_type,
    output logic              rsp_valid,
    output logic [31:0]       rsp_lin,
    output logic [1:0]        rsp_fault
);
    localparam int WR_BIT = 1;

    logic              prot_err;
    logic              lim_err;
    logic [ADDR_W-1:0] lin_nxt;
    seg_fault_e        flt_nxt;

    seg_lvl_check #(
        .LVL_W (LVL_W),
        .TYPE_W(TYPE_W),
        .WR_BIT(WR_BIT)
    ) u_lvl (
        .cur_lvl (cur_lvl),
        .rq_lvl  (req_sel[LVL_W-1:0]),
        .dsc_lvl (dsc_lvl),
        .dsc_type(dsc_type),
        .is_write(req_write),
        .prot_err(prot_err)
    );

    seg_lim_check #(
        .ADDR_W    (ADDR_W),
        .LIMIT_W   (LIMIT_W),
        .GRAN_SHIFT(GRAN_SHIFT),
        .SIZE_W    (SIZE_W)
    ) u_lim (
        .offset   (req_off),
        .size_log2(req_size),
        .limit    (dsc_limit),
        .gran     (dsc_gran),
        .lim_err  (lim_err)
    );

    // Linear address and ranked fault for the current request.
    always_comb begin
        lin_nxt = dsc_base + req_off;
        if (!dsc_present)
            flt_nxt = FLT_ABSENT;
        else if (prot_err)
            flt_nxt = FLT_PROT;
        else if (lim_err)
            flt_nxt = FLT_LIMIT;
        else
            flt_nxt = FLT_NONE;
    end

    // Result register stage; data only loads on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_lin   <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_lin   <= lin_nxt;
                rsp_fault <= flt_nxt;
            end
        end
    end
endmodule

// File: rtl/seg_access_check_sva.sv
// Module: assertion checker bound to seg_access_check.
// Relates request ports to the registered response one cycle later.
module seg_access_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_sel,
    input logic [1:0]  cur_lvl,
    input logic [31:0] req_off,
    input logic [31:0] dsc_base,
    input logic [1:0]  dsc_lvl,
    input logic        dsc_present,
    input logic        rsp_valid,
    input logic [31:0] rsp_lin,
    input logic [1:0]  rsp_fault
);
    logic [1:0] eff_lvl;
    assign eff_lvl = (cur_lvl > req_sel[1:0]) ? cur_lvl : req_sel[1:0];

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r1_lin_sum: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_lin == $past(dsc_base + req_off));
    a_r7_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dsc_present) |=> rsp_fault == 2'd1);
    a_r8_prot_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dsc_present && eff_lvl > dsc_lvl) |=> rsp_fault == 2'd2);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_fault) && $stable(rsp_lin)));
endmodule

bind seg_access_check seg_access_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .cur_lvl    (cur_lvl),
    .req_off    (req_off),
    .dsc_base   (dsc_base),
    .dsc_lvl    (dsc_lvl),
    .dsc_present(dsc_present),
    .rsp_valid  (rsp_valid),
    .rsp_lin    (rsp_lin),
    .rsp_fault  (rsp_fault)
);

// File: tb/tb_seg_access_check.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed reset/idle tests.
module tb_seg_access_check;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_sel;
    logic [1:0]  cur_lvl;
    logic [31:0] req_off;
    logic        req_write;
    logic [1:0]  req_size;
    logic [31:0] dsc_base;
    logic [19:0] dsc_limit;
    logic        dsc_gran;
    logic [1:0]  dsc_lvl;
    logic        dsc_present;
    logic [3:0]  dsc_type;
    logic        rsp_valid;
    logic [31:0] rsp_lin;
    logic [1:0]  rsp_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    seg_access_check dut (.*);

    typedef struct packed {
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic [31:0] off;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] base;
        logic [19:0] lim;
        logic        g;
        logic [1:0]  dpl;
        logic        p;
        logic [3:0]  typ;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 17;
    // exp: 0 none, 1 absent, 2 protection, 3 limit
    localparam vec_t VECS [NV] = '{
        '{16'hFFF8, 2'd0, 32'h0000_0100, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd0}, // R1 R3 index bits
        '{16'h0010, 2'd0, 32'h0000_0FFF, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd0}, // R4 exact
        '{16'h0010, 2'd0, 32'h0000_0FFE, 1'b0, 2'd1, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd0}, // R4 2B fits
        '{16'h0010, 2'd0, 32'h0000_0FFE, 1'b0, 2'd2, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd3}, // R4 4B over
        '{16'h0010, 2'd0, 32'h0000_1000, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd3}, // R4 one past
        '{16'h0010, 2'd0, 32'h0000_1FFF, 1'b0, 2'd0, 32'h0002_0000, 20'h00001, 1'b1, 2'd0, 1'b1, 4'h2, 2'd0}, // R5 scaled edge
        '{16'h0010, 2'd0, 32'h0000_2000, 1'b0, 2'd0, 32'h0002_0000, 20'h00001, 1'b1, 2'd0, 1'b1, 4'h2, 2'd3}, // R5 past
        '{16'h0010, 2'd0, 32'hFFFF_FFFC, 1'b0, 2'd2, 32'h0000_0000, 20'hFFFFF, 1'b1, 2'd0, 1'b1, 4'h2, 2'd0}, // R5 top
        '{16'h0010, 2'd0, 32'hFFFF_FFFE, 1'b0, 2'd2, 32'h0000_0000, 20'hFFFFF, 1'b1, 2'd0, 1'b1, 4'h2, 2'd3}, // R4 wrap
        '{16'h0010, 2'd3, 32'h0000_0010, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd2, 1'b1, 4'h2, 2'd2}, // R3 cur
        '{16'h0013, 2'd0, 32'h0000_0010, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd2, 1'b1, 4'h2, 2'd2}, // R3 rpl
        '{16'h0009, 2'd2, 32'h0000_0010, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd2, 1'b1, 4'h2, 2'd0}, // R3 equal
        '{16'h0010, 2'd3, 32'h0001_0000, 1'b1, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b0, 4'h0, 2'd1}, // R7 R8
        '{16'h0010, 2'd3, 32'h0001_0000, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h2, 2'd2}, // R8 prot>lim
        '{16'h0010, 2'd0, 32'h0000_0020, 1'b1, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h0, 2'd2}, // R6 ro write
        '{16'h0010, 2'd0, 32'h0000_0020, 1'b0, 2'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 2'd0, 1'b1, 4'h0, 2'd0}, // R6 ro read
        '{16'h0010, 2'd0, 32'h0000_2000, 1'b1, 2'd3, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 2'd0, 1'b1, 4'h2, 2'd0}  // R1 wrap
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_sel = v.sel; cur_lvl = v.cpl; req_off = v.off; req_write = v.wr;
        req_size = v.sz; dsc_base = v.base; dsc_limit = v.lim; dsc_gran = v.g;
        dsc_lvl = v.dpl; dsc_present = v.p; dsc_type = v.typ;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        chk("R9 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9 lin", rsp_lin, 32'd0);
        chk("R9 fault", {30'd0, rsp_fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle", {31'd0, rsp_valid}, 32'd0);

        // Table walk: back-to-back requests, each checked one cycle later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            chk("R2 valid", {31'd0, rsp_valid}, 32'd1);
            chk("R1 lin", rsp_lin, VECS[i].base + VECS[i].off);
            chk($sformatf("R8 fault vec %0d", i), {30'd0, rsp_fault}, {30'd0, VECS[i].exp});
        end

        // R10: idle cycle with changed inputs keeps the last result.
        req_valid = 1'b0;
        drive(VECS[12]);
        @(negedge clk);
        chk("R2 drop", {31'd0, rsp_valid}, 32'd0);
        chk("R10 lin hold", rsp_lin, VECS[NV-1].base + VECS[NV-1].off);
        chk("R10 fault hold", {30'd0, rsp_fault}, 32'd0);
        @(negedge clk);
        chk("R10 fault hold2", {30'd0, rsp_fault}, 32'd0);

        // R9: reset mid-run clears the result.
        drive(VECS[3]);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R4 before reset", {30'd0, rsp_fault}, 32'd3);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R9 re-reset fault", {30'd0, rsp_fault}, 32'd0);
        chk("R9 re-reset valid", {31'd0, rsp_valid}, 32'd0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule